// File: doc/BRIEF.md
# Configurable Ring Oscillator Stage Optimizer

This block chooses which inverter stages a pair of configurable ring oscillators should use. Each stage of a ring has a multiplexer that either keeps the inverter in the loop or steps around it on a plain wire. One selection vector drives both rings. Test equipment measures the delay of every inverter after manufacture and feeds those delays in, one stage per beat. The block then picks the selection vector that makes the difference between the two rings' total delays as large as possible.

When the start strobe arrives, the block evaluates the stored delays. One cycle later it presents the selection vector, the summed delay of each ring under that vector, the absolute gap and the response bit, together with a one-cycle done pulse. A ring needs an odd number of inverters to oscillate. The selection therefore always keeps an odd, non-zero count of stages. The oscillators themselves are outside this block.

Top module: `ring_stage_opt`

## Requirements
- R1: Every beat with `ld_en` high stores (`ld_top`, `ld_bot`) as the delays of the next stage. The first beat after reset or after a start goes to stage 0. The index wraps back to stage 0 after stage NSTAGE-1.
- R2: A `start` pulse produces results and a one-cycle `done` pulse in the following cycle. All result outputs keep their values until the next `start`.
- R3: Bit i of `cfg_vec` is 1 when stage i (stage 0 is the first loaded) keeps its inverter and 0 when the stage is bypassed. `top_total` and `bot_total` are the sums of the delays of the kept stages only.
- R4: Two candidate sets are compared. One holds the stages where the top delay exceeds the bottom delay. The other holds the stages where the bottom delay exceeds the top delay. Each set is scored by the sum of its stage differences, and the set with the larger sum is kept. On equal sums, the set where the top delay is larger wins. A stage with equal delays is never in either set.
- R5: If the kept set has an even number of stages, the stage in it with the smallest difference is removed. When several stages share that smallest difference, the one with the lowest index is removed.
- R6: If no stage has differing delays, `cfg_vec` selects stage 0 alone.
- R7: `gap` equals |`top_total` − `bot_total`|. `resp` is 1 exactly when `top_total` < `bot_total`.
- R8: After reset, `cfg_vec`, both totals, `gap`, `resp` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Stage delay load beat |
| ld_top | input | DW | Measured delay of the top ring's inverter for this stage |
| ld_bot | input | DW | Measured delay of the bottom ring's inverter for this stage |
| start | input | 1 | Begin evaluation of the stored delays |
| cfg_vec | output | NSTAGE | Per-stage include (1) / bypass (0) vector |
| top_total | output | SW | Top ring total delay under `cfg_vec` |
| bot_total | output | SW | Bottom ring total delay under `cfg_vec` |
| gap | output | SW | Absolute total delay difference |
| resp | output | 1 | 1 when the top ring is faster |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
The bench builds the block with its defaults: five stages and 8-bit delays. With five stages, every subset size from one to five can be reached. This covers the 28/25 whole-ring case rising to a gap of 6 on three stages, dropping one stage out of four, the all-equal fallback and a tie between the two sets. The 8-bit delays allow all-maximum inputs, which push the totals to the top of their width. Load wrap-around over seven beats and random delay sets complete the coverage.

// File: rtl/ring_opt_pkg.sv
package ring_opt_pkg;

    localparam int MAX_STAGES = 16;

    // which ring is slower on the chosen stages
    typedef enum logic {
        SLOW_TOP = 1'b0,
        SLOW_BOT = 1'b1
    } slow_side_e;

    function automatic int sum_width(input int dw, input int nstage);
        return dw + $clog2(nstage + 1);
    endfunction

endpackage

// File: rtl/ring_stage_store.sv
module ring_stage_store #(
    parameter int NSTAGE = 5,
    parameter int DW     = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         ld_en,
    input  logic [DW-1:0]                ld_top,
    input  logic [DW-1:0]                ld_bot,
    input  logic                         rewind,
    output logic [NSTAGE-1:0][DW-1:0]    top_dly,
    output logic [NSTAGE-1:0][DW-1:0]    bot_dly
);
    localparam int IW = (NSTAGE > 1) ? $clog2(NSTAGE) : 1;
    localparam logic [IW-1:0] LAST = IW'(NSTAGE - 1);

    logic [IW-1:0] wptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr    <= '0;
            top_dly <= '0;
            bot_dly <= '0;
        end else if (rewind) begin
            wptr <= '0;
        end else if (ld_en) begin
            top_dly[wptr] <= ld_top;
            bot_dly[wptr] <= ld_bot;
            wptr          <= (wptr == LAST) ? '0 : wptr + 1'b1;
        end
    end

    // R1: write index stays inside the stage range
    a_r1_ptr_range: assert property (@(posedge clk) disable iff (rst)
        int'(wptr) < NSTAGE);

endmodule

// File: rtl/ring_stage_pick.sv
module ring_stage_pick
    import ring_opt_pkg::*;
#(
    parameter int NSTAGE = 5,
    parameter int DW     = 8,
    parameter int SW     = DW + $clog2(NSTAGE + 1)
) (
    input  logic [NSTAGE-1:0][DW-1:0] top_dly,
    input  logic [NSTAGE-1:0][DW-1:0] bot_dly,
    output logic [NSTAGE-1:0]         sel,
    output logic [SW-1:0]             top_sum,
    output logic [SW-1:0]             bot_sum
);
    localparam int IW = (NSTAGE > 1) ? $clog2(NSTAGE) : 1;

    logic [NSTAGE-1:0]         up_m, dn_m, pick_m;
    logic [NSTAGE-1:0][DW-1:0] up_mag, dn_mag, mag;
    logic [SW-1:0]             up_sum, dn_sum;
    slow_side_e                side;
    logic [IW-1:0]             min_idx;
    logic [DW-1:0]             min_val;
    logic                      found;

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        assign up_m[g]   = top_dly[g] > bot_dly[g];
        assign dn_m[g]   = bot_dly[g] > top_dly[g];
        assign up_mag[g] = up_m[g] ? top_dly[g] - bot_dly[g] : '0;
        assign dn_mag[g] = dn_m[g] ? bot_dly[g] - top_dly[g] : '0;
    end

    // candidate scoring and sign choice (R4)
    always_comb begin
        up_sum = '0;
        dn_sum = '0;
        for (int i = 0; i < NSTAGE; i++) begin
            up_sum = up_sum + SW'(up_mag[i]);
            dn_sum = dn_sum + SW'(dn_mag[i]);
        end
        side   = (up_sum >= dn_sum) ? SLOW_TOP : SLOW_BOT;
        pick_m = (side == SLOW_TOP) ? up_m : dn_m;
        mag    = (side == SLOW_TOP) ? up_mag : dn_mag;
    end

    // smallest-difference member, lowest index first (R5)
    always_comb begin
        found   = 1'b0;
        min_idx = '0;
        min_val = '0;
        for (int i = 0; i < NSTAGE; i++) begin
            if (pick_m[i] && (!found || mag[i] < min_val)) begin
                found   = 1'b1;
                min_idx = IW'(i);
                min_val = mag[i];
            end
        end
    end

    // parity fix-up and empty fallback (R5, R6)
    always_comb begin
        sel = pick_m;
        if (pick_m == '0) begin
            sel = NSTAGE'(1);
        end else if (^pick_m == 1'b0) begin
            sel[min_idx] = 1'b0;
        end
    end

    // totals over kept stages (R3)
    always_comb begin
        top_sum = '0;
        bot_sum = '0;
        for (int i = 0; i < NSTAGE; i++) begin
            if (sel[i]) begin
                top_sum = top_sum + SW'(top_dly[i]);
                bot_sum = bot_sum + SW'(bot_dly[i]);
            end
        end
    end

endmodule

// File: rtl/ring_stage_opt.sv
module ring_stage_opt
    import ring_opt_pkg::*;
#(
    parameter int NSTAGE = 5,
    parameter int DW     = 8,
    parameter int SW     = DW + $clog2(NSTAGE + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [DW-1:0]     ld_top,
    input  logic [DW-1:0]     ld_bot,
    input  logic              start,
    output logic [NSTAGE-1:0] cfg_vec,
    output logic [SW-1:0]     top_total,
    output logic [SW-1:0]     bot_total,
    output logic [SW-1:0]     gap,
    output logic              resp,
    output logic              done
);
    logic [NSTAGE-1:0][DW-1:0] top_dly, bot_dly;
    logic [NSTAGE-1:0]         sel;
    logic [SW-1:0]             top_sum, bot_sum;

    ring_stage_store #(.NSTAGE(NSTAGE), .DW(DW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .ld_en   (ld_en),
        .ld_top  (ld_top),
        .ld_bot  (ld_bot),
        .rewind  (start),
        .top_dly (top_dly),
        .bot_dly (bot_dly)
    );

    ring_stage_pick #(.NSTAGE(NSTAGE), .DW(DW), .SW(SW)) u_pick (
        .top_dly (top_dly),
        .bot_dly (bot_dly),
        .sel     (sel),
        .top_sum (top_sum),
        .bot_sum (bot_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_vec   <= '0;
            top_total <= '0;
            bot_total <= '0;
            gap       <= '0;
            resp      <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= start;
            if (start) begin
                cfg_vec   <= sel;
                top_total <= top_sum;
                bot_total <= bot_sum;
                gap       <= (top_sum >= bot_sum) ? top_sum - bot_sum : bot_sum - top_sum;
                resp      <= top_sum < bot_sum;
            end
        end
    end

    // R5: an oscillating ring always has an odd, non-zero stage count
    a_r5_odd_count: assert property (@(posedge clk) disable iff (rst)
        done |-> ($countones(cfg_vec) % 2 == 1));

    // R2: done only ever follows a start
    a_r2_done_after_start: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(start));

    // R2: results hold while no start arrives
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(cfg_vec) && $stable(gap) && $stable(top_total) && $stable(bot_total)));

    // R7: gap closes the distance between the two totals
    a_r7_gap_rel: assert property (@(posedge clk) disable iff (rst)
        done |-> ((top_total == bot_total + gap) || (bot_total == top_total + gap)));

endmodule

// File: tb/ring_stage_opt_bench.sv
`timescale 1ns/1ps
module ring_stage_opt_bench;
    localparam int NSTAGE = 5;
    localparam int DW     = 8;
    localparam int SW     = DW + $clog2(NSTAGE + 1);

    typedef struct {
        logic [NSTAGE-1:0] cfg;
        int                ttop;
        int                tbot;
        int                gap;
        logic              resp;
        string             req;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ld_en = 1'b0;
    logic [DW-1:0]     ld_top = '0;
    logic [DW-1:0]     ld_bot = '0;
    logic              start = 1'b0;
    logic [NSTAGE-1:0] cfg_vec;
    logic [SW-1:0]     top_total, bot_total, gap;
    logic              resp, done;

    int   n_checks = 0;
    int   n_fail   = 0;
    exp_t sbq[$];
    int   mtop[NSTAGE];
    int   mbot[NSTAGE];
    int   mptr = 0;
    exp_t last_exp;

    always #5 clk = ~clk;

    ring_stage_opt #(.NSTAGE(NSTAGE), .DW(DW)) u_ring_stage_opt (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_top(ld_top), .ld_bot(ld_bot),
        .start(start), .cfg_vec(cfg_vec), .top_total(top_total),
        .bot_total(bot_total), .gap(gap), .resp(resp), .done(done)
    );

    function automatic exp_t model(input string req);
        exp_t e;
        int   su = 0, sd = 0, cnt = 0, mi = -1, mv = 0, d;
        logic use_up;
        for (int i = 0; i < NSTAGE; i++) begin
            if (mtop[i] > mbot[i]) su += mtop[i] - mbot[i];
            if (mbot[i] > mtop[i]) sd += mbot[i] - mtop[i];
        end
        use_up = (su >= sd);
        e.cfg = '0;
        for (int i = 0; i < NSTAGE; i++) begin
            d = use_up ? mtop[i] - mbot[i] : mbot[i] - mtop[i];
            if (d > 0) begin
                e.cfg[i] = 1'b1;
                cnt++;
                if (mi < 0 || d < mv) begin mi = i; mv = d; end
            end
        end
        if (cnt == 0) e.cfg = NSTAGE'(1);
        else if (cnt % 2 == 0) e.cfg[mi] = 1'b0;
        e.ttop = 0; e.tbot = 0;
        for (int i = 0; i < NSTAGE; i++)
            if (e.cfg[i]) begin e.ttop += mtop[i]; e.tbot += mbot[i]; end
        e.gap  = (e.ttop >= e.tbot) ? e.ttop - e.tbot : e.tbot - e.ttop;
        e.resp = e.ttop < e.tbot;
        e.req  = req;
        return e;
    endfunction

    task automatic load_one(input int t, input int b);
        @(posedge clk); #1;
        ld_en = 1'b1; ld_top = DW'(t); ld_bot = DW'(b);
        mtop[mptr] = t; mbot[mptr] = b;
        mptr = (mptr == NSTAGE - 1) ? 0 : mptr + 1;
        @(posedge clk); #1;
        ld_en = 1'b0;
    endtask

    task automatic run(input string req);
        exp_t e;
        e = model(req);
        sbq.push_back(e);
        last_exp = e;
        @(posedge clk); #1;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        mptr = 0;
        repeat (3) @(posedge clk);
    endtask

    task automatic run_set(input int t[NSTAGE], input int b[NSTAGE], input string req);
        for (int i = 0; i < NSTAGE; i++) load_one(t[i], b[i]);
        run(req);
    endtask

    task automatic check_out(input exp_t e, input string tag);
        n_checks++;
        if (cfg_vec !== e.cfg || int'(top_total) != e.ttop || int'(bot_total) != e.tbot ||
            int'(gap) != e.gap || resp !== e.resp) begin
            n_fail++;
            $display("FAIL %s %s: got cfg=%b top=%0d bot=%0d gap=%0d resp=%b exp cfg=%b top=%0d bot=%0d gap=%0d resp=%b",
                e.req, tag, cfg_vec, top_total, bot_total, gap, resp,
                e.cfg, e.ttop, e.tbot, e.gap, e.resp);
        end
    endtask

    // monitor: pop an expected item whenever done is seen
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sbq.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R2 unexpected done: got done=1 exp done=0");
            end else begin
                check_out(sbq.pop_front(), "result");
            end
        end
    end

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL R2 watchdog: got no finish exp finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        exp_t z;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        z.cfg = '0; z.ttop = 0; z.tbot = 0; z.gap = 0; z.resp = 1'b0; z.req = "R8";
        check_out(z, "reset");
        n_checks++;
        if (done !== 1'b0) begin n_fail++; $display("FAIL R8 done: got %b exp 0", done); end

        // R3 worked case: totals 28/25 on all stages, best three stages give gap 6
        run_set('{5,5,6,6,6}, '{7,6,4,4,4}, "R3");
        // R5 even count: four up stages, smallest (stage 1) dropped
        run_set('{10,5,9,7,2}, '{7,4,5,5,2}, "R5");
        // R5 tie on smallest difference: lowest index dropped
        run_set('{4,4,9,9,0}, '{2,2,3,3,0}, "R5");
        // R4 bottom-slower set wins
        run_set('{1,2,9,1,1}, '{8,7,3,6,1}, "R4");
        // R4 equal sums: top-slower set kept
        run_set('{3,1,0,0,0}, '{1,3,0,0,0}, "R4");
        // R6 all equal
        run_set('{7,7,7,7,7}, '{7,7,7,7,7}, "R6");
        // R7 extremes: top fastest everywhere
        run_set('{0,0,0,0,0}, '{255,255,255,255,255}, "R7");

        // R2 hold: outputs unchanged several cycles after done
        repeat (5) @(posedge clk);
        @(negedge clk);
        check_out(last_exp, "hold");

        // R1 wrap: seven beats, stages 0 and 1 overwritten by beats 6 and 7
        for (int i = 0; i < 7; i++) load_one(10 + i * 3, 40 - i * 5);
        run("R1");
        // R1 rewind: after start, next beat goes to stage 0 again
        load_one(200, 1);
        run("R1");

        // R4/R7 random sets
        for (int k = 0; k < 20; k++) begin
            int t[NSTAGE];
            int b[NSTAGE];
            for (int i = 0; i < NSTAGE; i++) begin
                t[i] = int'($urandom_range(0, 255));
                b[i] = (k % 4 == 0) ? t[i] : int'($urandom_range(0, 255));
                if (k % 4 == 0 && i == k % NSTAGE) b[i] = int'($urandom_range(0, 255));
            end
            run_set(t, b, "R4");
        end

        repeat (4) @(posedge clk);
        n_checks++;
        if (sbq.size() != 0) begin
            n_fail++;
            $display("FAIL R2 missing done: got %0d pending exp 0", sbq.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule